// File: doc/BRIEF.md
# Breakpoint Run and Paged Test Controller

This block supervises execution runs of a processor core for a host. The host sends commands, each made of an 8-bit opcode and a 24-bit immediate. Some commands only store settings: the run timeout in core cycles, the breakpoint address (taken from the immediate or from an accumulator value) and the page size. One command hands memory priority to the core. A run command holds the core in reset for a fixed number of cycles, then lets the core clock run. It counts cycles until the core's fetch address equals the breakpoint or the count reaches the timeout. It then returns two response words: a fixed tag and a packed status word.

A batch command repeats the reset-and-run sequence once per memory page. It moves a page base address forward by the page size before each new page. One completion word follows the last page. The core holds memory priority for as long as a run or a batch is active. Priority returns to the host when the final response word has been sent.

Top module: `bp_run_ctrl`

## Requirements
- R1: After reset, core_rst, core_run, core_prio, busy and rsp_valid are low and page_base is zero. At most one of core_rst, core_run and rsp_valid is high in any cycle.
- R2: Opcode 0x75 starts a run. From the next cycle, core_rst is high for exactly RST_CYCLES cycles, with core_prio high and core_run low. core_run then goes high.
- R3: During a run, in the k-th cycle with core_run high (k counted from 0), fetch_addr equal to the breakpoint ends the run with status word {k as 24 bits, 8'h00}.
- R4: Opcode 0x54 sets the timeout T from the immediate. A run that has not met the breakpoint ends in run cycle k = T with status word {T, 8'h01}. The breakpoint wins when both occur in the same cycle.
- R5: The cycle after a single run ends, rsp_valid is high with rsp_data = 32'h6C75636B. In the following cycle rsp_valid is high with the status word. busy falls after that.
- R6: Opcode 0x44 loads the breakpoint from immediate bits [ADDR_W-1:0]. Opcode 0x64 loads it from acc_value bits [ADDR_W-1:0].
- R7: Opcode 0x4F raises core_prio while idle. core_prio stays high through the next run or batch and is low in the cycle after busy falls.
- R8: Opcode 0x50 sets the page size S. Opcode 0x45 with immediate N > 0 performs N reset-and-run rounds, with page_base = i*S during round i. It sends no per-round status. It ends with one response word 32'h676F6F64.
- R9: Opcode 0x45 with immediate 0 returns 32'h676F6F64 without resetting the core.
- R10: Commands received while busy is high are ignored, and so are unknown opcodes. busy is high whenever core_rst, core_run or rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 8 | Command opcode |
| cmd_imm | input | 24 | Command immediate |
| acc_value | input | 32 | Current host accumulator value |
| fetch_addr | input | ADDR_W | Core instruction fetch address |
| core_rst | output | 1 | Reset request to the core |
| core_run | output | 1 | Core clock enable |
| core_prio | output | 1 | Memory priority select, 1 = core |
| page_base | output | ADDR_W | Base address of the active test page |
| busy | output | 1 | A run, batch or response is in progress |
| rsp_valid | output | 1 | Response word strobe |
| rsp_data | output | 32 | Response word |

## Verification
The hardest case to reach is a batch whose rounds end in different ways. The breakpoint must hit on one page and the timeout must expire on others, and the page base must still advance correctly between rounds. The bench models the core as a fetch counter that restarts at page_base on reset and steps once per enabled cycle. It places an absolute breakpoint inside the first page only, so the first round stops early and the later rounds run to the timeout. The bench then checks the base seen at each reset and the total count of enabled cycles. Busy-time commands are issued in the middle of the reset phase and judged by the status word of that run.

// File: rtl/bp_run_ctrl.sv
module bp_run_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int RST_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [23:0]       cmd_imm,
  input  logic [31:0]       acc_value,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              core_rst,
  output logic              core_run,
  output logic              core_prio,
  output logic [ADDR_W-1:0] page_base,
  output logic              busy,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam logic [RCW-1:0] RC_LAST = RCW'(RST_CYCLES - 1);
  localparam logic [31:0] TAG_RUN  = 32'h6C75636B;
  localparam logic [31:0] TAG_DONE = 32'h676F6F64;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_RUN, S_TAG, S_STAT, S_DONE} state_t;

  state_t             state;
  logic [23:0]        tmo_q, cyc_q, npages_q, pg_q;
  logic [ADDR_W-1:0]  bp_q, psize_q, base_q;
  logic [RCW-1:0]     rcnt;
  logic               to_q, batch_q, prio_q;

  wire hit       = fetch_addr == bp_q;
  wire expire    = cyc_q == tmo_q;
  wire last_page = (pg_q + 24'd1) == npages_q;

  assign core_rst  = state == S_RST;
  assign core_run  = state == S_RUN;
  assign busy      = state != S_IDLE;
  assign core_prio = prio_q | busy;
  assign page_base = base_q;
  assign rsp_valid = state == S_TAG || state == S_STAT || state == S_DONE;
  assign rsp_data  = state == S_TAG  ? TAG_RUN :
                     state == S_STAT ? {cyc_q, 7'd0, to_q} :
                     state == S_DONE ? TAG_DONE : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmo_q    <= '0;
      cyc_q    <= '0;
      npages_q <= '0;
      pg_q     <= '0;
      bp_q     <= '0;
      psize_q  <= '0;
      base_q   <= '0;
      rcnt     <= '0;
      to_q     <= 1'b0;
      batch_q  <= 1'b0;
      prio_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          case (cmd_op)
            8'h54: tmo_q   <= cmd_imm;
            8'h44: bp_q    <= cmd_imm[ADDR_W-1:0];
            8'h64: bp_q    <= acc_value[ADDR_W-1:0];
            8'h50: psize_q <= cmd_imm[ADDR_W-1:0];
            8'h4F: prio_q  <= 1'b1;
            8'h75: begin
              batch_q <= 1'b0;
              base_q  <= '0;
              rcnt    <= '0;
              state   <= S_RST;
            end
            8'h45: begin
              if (cmd_imm == 24'd0) begin
                state <= S_DONE;
              end else begin
                batch_q  <= 1'b1;
                npages_q <= cmd_imm;
                pg_q     <= '0;
                base_q   <= '0;
                rcnt     <= '0;
                state    <= S_RST;
              end
            end
            default: ;
          endcase
        end
        S_RST: begin
          if (rcnt == RC_LAST) begin
            cyc_q <= '0;
            state <= S_RUN;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        S_RUN: begin
          if (hit || expire) begin
            to_q <= !hit;
            if (!batch_q) begin
              state <= S_TAG;
            end else if (last_page) begin
              state <= S_DONE;
            end else begin
              pg_q   <= pg_q + 24'd1;
              base_q <= base_q + psize_q;
              rcnt   <= '0;
              state  <= S_RST;
            end
          end else if (cyc_q != '1) begin
            cyc_q <= cyc_q + 24'd1;
          end
        end
        S_TAG:  state <= S_STAT;
        S_STAT: begin
          prio_q <= 1'b0;
          state  <= S_IDLE;
        end
        S_DONE: begin
          prio_q  <= 1'b0;
          batch_q <= 1'b0;
          base_q  <= '0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bp_run_ctrl_chk.sv
module bp_run_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst,
  input logic              core_run,
  input logic              core_prio,
  input logic              busy,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] bp_q,
  input logic              batch_q
);
  // R1
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_rst, core_run, rsp_valid}));

  // R2
  rst_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> core_prio && !core_run);

  // R3
  bp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && fetch_addr == bp_q && !batch_q |=> rsp_valid && rsp_data == 32'h6C75636B);

  // R5
  tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_data == 32'h6C75636B |=> rsp_valid && rsp_data[7:1] == 7'd0);

  // R7
  prio_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !core_prio);

  // R10
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst || core_run || rsp_valid) |-> busy);
endmodule

bind bp_run_ctrl bp_run_ctrl_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .core_run(core_run),
  .core_prio(core_prio), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .fetch_addr(fetch_addr), .bp_q(bp_q), .batch_q(batch_q)
);

// File: tb/bp_run_ctrl_test.sv
module bp_run_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int RSTC = 20;
  localparam logic [31:0] TAG_RUN  = 32'h6C75636B;
  localparam logic [31:0] TAG_DONE = 32'h676F6F64;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_op = 0;
  logic [23:0] cmd_imm = 0;
  logic [31:0] acc_value = 0;
  logic [ADDR_W-1:0] fetch_addr;
  logic core_rst, core_run, core_prio, busy, rsp_valid;
  logic [ADDR_W-1:0] page_base;
  logic [31:0] rsp_data;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_run_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .acc_value(acc_value), .fetch_addr(fetch_addr), .core_rst(core_rst), .core_run(core_run),
    .core_prio(core_prio), .page_base(page_base), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  // core model: fetch restarts at page base on reset, steps when enabled
  always_ff @(posedge clk) begin
    if (!rst_n) fetch_addr <= '0;
    else if (core_rst) fetch_addr <= page_base;
    else if (core_run) fetch_addr <= fetch_addr + 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] imm);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_imm = imm;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; cmd_imm = 0;
  endtask

  // after a 0x75 send: count reset and run cycles, capture two words
  task automatic collect_run(output int rc, output int rn, output logic [31:0] w0,
                             output logic [31:0] w1, input bit poke);
    rc = 0; rn = 0; w0 = 0; w1 = 0;
    for (int i = 0; i < 5000; i++) begin
      if (poke && rc == 3) begin
        cmd_valid = 1; cmd_op = 8'h54; cmd_imm = 24'd2;
      end else if (poke && rc == 5) begin
        cmd_valid = 1; cmd_op = 8'h44; cmd_imm = 24'd1;
      end else begin
        cmd_valid = 0; cmd_op = 0; cmd_imm = 0;
      end
      if (core_rst) rc++;
      if (core_run) rn++;
      if (rsp_valid) begin
        w0 = rsp_data;
        @(negedge clk);
        w1 = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 core_rst", {31'd0, core_rst}, 0);
    check("R1 core_run", {31'd0, core_run}, 0);
    check("R1 core_prio", {31'd0, core_prio}, 0);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    check("R1 page_base", {16'd0, page_base}, 0);
  endtask

  task automatic t_bp_run();
    int rc, rn; logic [31:0] w0, w1;
    send(8'h54, 24'd100);
    send(8'h44, 24'd7);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 0);
    check("R2 reset length", rc, RSTC);
    check("R3 run cycles", rn, 8);
    check("R5 tag word", w0, TAG_RUN);
    check("R3 status", w1, {24'd7, 8'h00});
    check("R5 busy after", {31'd0, busy}, 0);
  endtask

  task automatic t_timeout();
    int rc, rn; logic [31:0] w0, w1;
    send(8'h54, 24'd12);
    send(8'h44, 24'd500);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 0);
    check("R4 run cycles", rn, 13);
    check("R4 status", w1, {24'd12, 8'h01});
    send(8'h44, 24'd12);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 0);
    check("R4 tie goes to breakpoint", w1, {24'd12, 8'h00});
  endtask

  task automatic t_acc_bp();
    int rc, rn; logic [31:0] w0, w1;
    send(8'h54, 24'd100);
    acc_value = 32'hABCD_0009;
    send(8'h64, 0);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 0);
    check("R6 acc breakpoint", w1, {24'd9, 8'h00});
  endtask

  task automatic t_prio();
    int rc, rn; logic [31:0] w0, w1;
    send(8'h4F, 0);
    check("R7 prio while idle", {31'd0, core_prio}, 1);
    check("R7 idle after 4F", {31'd0, busy}, 0);
    send(8'h44, 24'd3);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 0);
    check("R7 prio released", {31'd0, core_prio}, 0);
  endtask

  task automatic t_busy_ignore();
    int rc, rn; logic [31:0] w0, w1;
    send(8'h54, 24'd30);
    send(8'h44, 24'd1000);
    send(8'h99, 24'd5);
    check("R10 unknown op idle", {30'd0, busy, core_rst}, 0);
    send(8'h75, 0);
    collect_run(rc, rn, w0, w1, 1);
    check("R10 settings unchanged", w1, {24'd30, 8'h01});
  endtask

  task automatic t_batch();
    int rounds = 0, rn = 0, rc = 0, early = 0;
    logic [ADDR_W-1:0] bases[3];
    logic [31:0] w = 0;
    logic prev_rst = 0;
    send(8'h50, 24'h40);
    send(8'h54, 24'd10);
    send(8'h44, 24'd5);
    send(8'h45, 24'd3);
    for (int i = 0; i < 5000; i++) begin
      if (core_rst && !prev_rst) begin
        if (rounds < 3) bases[rounds] = page_base;
        rounds++;
      end
      prev_rst = core_rst;
      if (core_rst) rc++;
      if (core_run) rn++;
      if (rsp_valid) begin
        w = rsp_data;
        if (w != TAG_DONE) early++;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    check("R8 rounds", rounds, 3);
    check("R8 base page0", {16'd0, bases[0]}, 32'h0);
    check("R8 base page1", {16'd0, bases[1]}, 32'h40);
    check("R8 base page2", {16'd0, bases[2]}, 32'h80);
    check("R8 run cycles total", rn, 28);
    check("R8 reset cycles total", rc, 3*RSTC);
    check("R8 done word", w, TAG_DONE);
    check("R8 no per-round words", early, 0);
    check("R8 busy done", {31'd0, busy}, 0);
  endtask

  task automatic t_batch_zero();
    int rc = 0; logic [31:0] w = 0;
    send(8'h45, 24'd0);
    for (int i = 0; i < 50; i++) begin
      if (core_rst) rc++;
      if (rsp_valid) begin w = rsp_data; @(negedge clk); break; end
      @(negedge clk);
    end
    check("R9 done word", w, TAG_DONE);
    check("R9 no core reset", rc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bp_run();
    t_timeout();
    t_acc_bp();
    t_prio();
    t_busy_ignore();
    t_batch();
    t_batch_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule